// File: doc/BRIEF.md
# Power Domain Switching Sequencer

The block turns a software request to power one gateable domain up or down into the timed series of control-bit changes that the domain's power switch, reset, isolation cells and clock gate need. It holds four per-domain control vectors (clock enable, isolation enable, reset release, power enable) and takes in a per-domain power-acknowledge vector from the analog switches. A power-enable vector bit can be active high or active low per domain, as chosen by a parameter mask.

Software writes one command word that holds a domain index and a direction. The sequencer then drives the addressed domain's bits in a fixed order. It waits a settle time after each clock, isolation and reset step. It polls the acknowledge of the power switch with a bounded number of samples. It ends with a done flag and, on a timeout or a bad index, an error flag. All timing comes from one prescaler that counts core clock cycles per microsecond. Only one request runs at a time.

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset, every clock-enable bit is 0, every isolation bit is 1 and every reset-release bit is 0. Each power-enable bit sits at its off level: 0 for an active-high domain, 1 for a domain whose bit in `PWR_LOW_MASK` is set. The status register (offset 0x04) reads 0.
- R2: A power-up command (write to offset 0x00 with bit 8 = 1 and the domain index in bits 7:0) first turns the power request on. When the synchronized acknowledge is seen high, it then sets reset release, then clears isolation, then sets clock enable. It ends with status done (bit 1) set and error (bit 2) clear.
- R3: A power-down command (bit 8 = 0) clears clock enable, then sets isolation, then clears reset release, then turns the power request off. When the acknowledge is seen low, the request ends with done set.
- R4: Each clock, isolation or reset step is followed by a settle time of `SETTLE_US` ticks. The next step's output change comes `SETTLE_US*TICK_CYCLES+1` cycles after the previous one. Busy (status bit 0) clears `SETTLE_US*TICK_CYCLES` cycles after the final clock-enable step of a power-up.
- R5: The acknowledge is sampled once every `TICK_CYCLES` cycles, for at most `POLL_MAX` samples. If the expected level is never seen, busy clears `POLL_MAX*TICK_CYCLES` cycles after the power request changed. Status then shows error and done, and none of the remaining steps is performed.
- R6: For a domain with its `PWR_LOW_MASK` bit set, turning power on drives its power-enable bit to 0, and turning power off drives it to 1.
- R7: A sequence changes only the bits of the addressed domain, and at most one control bit changes in any cycle. While idle, no control bit changes.
- R8: A command written while busy is ignored and sets the sticky overrun bit (status bit 3). The running sequence completes normally.
- R9: A command whose index is not below `NUM_DOM` changes no control bit. It sets done and error in the cycle after the write and never sets busy.
- R10: Reads return clock enable at 0x18, isolation at 0x1C, reset release at 0x20, the power-enable pins at 0x24 and the synchronized acknowledge at 0x28. Each domain uses the bit equal to its index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pwr_ack_i | input | NUM_DOM | Power-switch acknowledge per domain, asynchronous |
| clk_en_o | output | NUM_DOM | Clock enable per domain |
| iso_en_o | output | NUM_DOM | Isolation enable per domain |
| rst_rel_o | output | NUM_DOM | Reset release per domain (1 = running) |
| pwr_en_o | output | NUM_DOM | Power-enable pin per domain, polarity per mask |

## Verification
A command is taken at the clock edge where `wr_en` is sampled, and busy reads high in the cycle after it. The first control bit changes one edge later, and each settled step follows its predecessor by exactly 21 cycles at the default settle and prescale values. A final power-up settle ends busy 20 cycles after clock enable. A poll timeout ends busy 4000 cycles after the power request changed. A monitor stamps, at falling edges, the cycle in which each bit of the watched domain changes and the cycle in which busy falls. The checks compare differences of these stamps against those counts. They do not compare absolute times, because the acknowledge arrives after a model delay that the requirements do not fix.

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq #(
  parameter int NUM_DOM = 12,
  parameter int TICK_CYCLES = 4,
  parameter int SETTLE_US = 5,
  parameter int POLL_MAX = 1000,
  parameter logic [NUM_DOM-1:0] PWR_LOW_MASK = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [7:0]         addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  input  logic [NUM_DOM-1:0] pwr_ack_i,
  output logic [NUM_DOM-1:0] clk_en_o,
  output logic [NUM_DOM-1:0] iso_en_o,
  output logic [NUM_DOM-1:0] rst_rel_o,
  output logic [NUM_DOM-1:0] pwr_en_o
);
  localparam int SETTLE_CYC = SETTLE_US * TICK_CYCLES;
  localparam int TW = $clog2(SETTLE_CYC + 1);
  localparam int PW = $clog2(POLL_MAX + 1);
  localparam int IW = $clog2(NUM_DOM);

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_SETTLE, S_POLL} st_t;

  st_t st;
  logic [1:0] step;
  logic up;
  logic [IW-1:0] idx;
  logic [TW-1:0] tmr;
  logic [PW-1:0] smp;
  logic busy, done, err, ovr;
  logic [NUM_DOM-1:0] clk_q, iso_q, rst_q, pon_q, ack_s1, ack_s2;

  logic cmd_wr, settle_end, tick, ack_ok, poll_step, cmd_valid;
  logic [NUM_DOM-1:0] sel;

  assign cmd_wr     = wr_en && addr == 8'h00;
  assign cmd_valid  = 32'(wdata[7:0]) < NUM_DOM;
  assign sel        = {{(NUM_DOM-1){1'b0}}, 1'b1} << idx;
  assign settle_end = tmr == TW'(SETTLE_CYC - 1);
  assign tick       = tmr == TW'(TICK_CYCLES - 1);
  assign ack_ok     = (|(ack_s2 & sel)) == up;
  assign poll_step  = up ? step == 2'd0 : step == 2'd3;

  assign clk_en_o  = clk_q;
  assign iso_en_o  = iso_q;
  assign rst_rel_o = rst_q;
  assign pwr_en_o  = pon_q ^ PWR_LOW_MASK;

  always_comb begin
    case (addr)
      8'h04:   rdata = {28'd0, ovr, err, done, busy};
      8'h18:   rdata = 32'(clk_q);
      8'h1C:   rdata = 32'(iso_q);
      8'h20:   rdata = 32'(rst_q);
      8'h24:   rdata = 32'(pwr_en_o);
      8'h28:   rdata = 32'(ack_s2);
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      step <= '0;
      up <= 1'b0;
      idx <= '0;
      tmr <= '0;
      smp <= '0;
      busy <= 1'b0;
      done <= 1'b0;
      err <= 1'b0;
      ovr <= 1'b0;
      clk_q <= '0;
      iso_q <= '1;
      rst_q <= '0;
      pon_q <= '0;
      ack_s1 <= '0;
      ack_s2 <= '0;
    end else begin
      ack_s1 <= pwr_ack_i;
      ack_s2 <= ack_s1;
      if (cmd_wr && busy) ovr <= 1'b1;
      case (st)
        S_IDLE: begin
          if (cmd_wr) begin
            if (cmd_valid) begin
              done <= 1'b0;
              err <= 1'b0;
              busy <= 1'b1;
              st <= S_ACT;
              step <= '0;
              up <= wdata[8];
              idx <= wdata[IW-1:0];
            end else begin
              done <= 1'b1;
              err <= 1'b1;
            end
          end
        end
        S_ACT: begin
          tmr <= '0;
          smp <= '0;
          if (up) begin
            case (step)
              2'd0: pon_q <= pon_q | sel;
              2'd1: rst_q <= rst_q | sel;
              2'd2: iso_q <= iso_q & ~sel;
              default: clk_q <= clk_q | sel;
            endcase
          end else begin
            case (step)
              2'd0: clk_q <= clk_q & ~sel;
              2'd1: iso_q <= iso_q | sel;
              2'd2: rst_q <= rst_q & ~sel;
              default: pon_q <= pon_q & ~sel;
            endcase
          end
          st <= poll_step ? S_POLL : S_SETTLE;
        end
        S_SETTLE: begin
          tmr <= tmr + 1'b1;
          if (settle_end) begin
            if (up && step == 2'd3) begin
              st <= S_IDLE;
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              step <= step + 1'b1;
              st <= S_ACT;
            end
          end
        end
        default: begin
          if (tick) begin
            tmr <= '0;
            smp <= smp + 1'b1;
            if (ack_ok) begin
              if (up) begin
                step <= 2'd1;
                st <= S_ACT;
              end else begin
                st <= S_IDLE;
                busy <= 1'b0;
                done <= 1'b1;
              end
            end else if (smp == PW'(POLL_MAX - 1)) begin
              st <= S_IDLE;
              busy <= 1'b0;
              done <= 1'b1;
              err <= 1'b1;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

module pwr_domain_seq_chk #(
  parameter int NUM_DOM = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [7:0]         addr,
  input logic               busy,
  input logic               ovr,
  input logic [NUM_DOM-1:0] clk_en_o,
  input logic [NUM_DOM-1:0] iso_en_o,
  input logic [NUM_DOM-1:0] rst_rel_o,
  input logic [NUM_DOM-1:0] pwr_en_o
);
  p_clk_iso_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_o & iso_en_o) == '0)
    else $error("clock enabled while isolated");

  p_clk_rst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_o & ~rst_rel_o) == '0)
    else $error("clock enabled while reset held");

  p_one_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({clk_en_o ^ $past(clk_en_o), iso_en_o ^ $past(iso_en_o),
                rst_rel_o ^ $past(rst_rel_o), pwr_en_o ^ $past(pwr_en_o)}) <= 1)
    else $error("more than one control bit changed");

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(clk_en_o) && $stable(iso_en_o) && $stable(rst_rel_o) && $stable(pwr_en_o)))
    else $error("control bit changed while idle");

  p_overrun_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h00 && busy) |=> ovr)
    else $error("overrun not flagged");

  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> ovr)
    else $error("overrun flag lost");
endmodule

bind pwr_domain_seq pwr_domain_seq_chk #(.NUM_DOM(NUM_DOM)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .busy(busy), .ovr(ovr),
  .clk_en_o(clk_en_o), .iso_en_o(iso_en_o), .rst_rel_o(rst_rel_o), .pwr_en_o(pwr_en_o)
);

// File: tb/pwr_domain_seq_test.sv
module pwr_domain_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 12;
  localparam int TICK = 4;
  localparam int SETTLE = 5;
  localparam int POLL = 1000;
  localparam logic [ND-1:0] MASK = 12'h820;
  localparam int GAP = SETTLE * TICK + 1;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0] addr = 8'h04;
  logic [31:0] wdata = '0, rdata;
  logic [ND-1:0] pwr_ack, clk_en, iso_en, rst_rel, pwr_en;
  logic [ND-1:0] p1 = '0, p2 = '0, p3 = '0, stuck_lo = '0, stuck_hi = '0;
  int errors = 0, checks = 0, cyc = 0;
  int mon = 0, t_clk, t_iso, t_rst, t_pwr, t_end;
  logic pc, pi, pr, pp, pb;
  bit finished = 0;

  pwr_domain_seq #(.NUM_DOM(ND), .TICK_CYCLES(TICK), .SETTLE_US(SETTLE),
    .POLL_MAX(POLL), .PWR_LOW_MASK(MASK)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pwr_ack_i(pwr_ack), .clk_en_o(clk_en), .iso_en_o(iso_en), .rst_rel_o(rst_rel),
    .pwr_en_o(pwr_en));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    p1 <= pwr_en ^ MASK;
    p2 <= p1;
    p3 <= p2;
  end
  assign pwr_ack = (p3 & ~stuck_lo) | stuck_hi;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (clk_en[mon] != pc) t_clk <= cyc;
    if (iso_en[mon] != pi) t_iso <= cyc;
    if (rst_rel[mon] != pr) t_rst <= cyc;
    if (pwr_en[mon] != pp) t_pwr <= cyc;
    if (addr == 8'h04 && pb && !rdata[0]) t_end <= cyc;
    pc <= clk_en[mon]; pi <= iso_en[mon]; pr <= rst_rel[mon]; pp <= pwr_en[mon];
    if (addr == 8'h04) pb <= rdata[0];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
    addr = 8'h04;
  endtask

  task automatic command(input int d, input bit on);
    @(negedge clk);
    t_clk = 0; t_iso = 0; t_rst = 0; t_pwr = 0; t_end = 0;
    mon = (d < ND) ? d : 0;
    wr_en = 1; addr = 8'h00; wdata = {23'd0, on, 8'(d)};
    @(negedge clk);
    wr_en = 0; addr = 8'h04;
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      #1;
      if (!rdata[0]) break;
    end
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 clk_en", 32'(clk_en), 0);
    chk("R1 iso_en", 32'(iso_en), 32'hFFF);
    chk("R1 rst_rel", 32'(rst_rel), 0);
    chk("R1 pwr_en", 32'(pwr_en), 32'(MASK));
    rd(8'h04, d); chk("R1 status", d, 0);
    rd(8'h1C, d); chk("R10 iso read", d, 32'hFFF);
    rd(8'h24, d); chk("R10 pwr read", d, 32'(MASK));
  endtask

  task automatic t_up3;
    logic [31:0] d;
    command(3, 1); wait_idle();
    chk("R2 order pwr<rst", 32'(t_rst > t_pwr && t_pwr > 0), 1);
    chk("R4 gap rst->iso", 32'(t_iso - t_rst), GAP);
    chk("R4 gap iso->clk", 32'(t_clk - t_iso), GAP);
    chk("R4 clk->idle", 32'(t_end - t_clk), GAP - 1);
    rd(8'h04, d); chk("R2 status", d, 32'h2);
    rd(8'h18, d); chk("R10 clk read", d, 32'h008);
    chk("R7 iso others", 32'(iso_en), 32'hFF7);
    chk("R7 rst others", 32'(rst_rel), 32'h008);
    chk("R7 pwr others", 32'(pwr_en), 32'(MASK ^ 12'h008));
    rd(8'h28, d); chk("R10 ack read", d, 32'h008);
  endtask

  task automatic t_down3;
    logic [31:0] d;
    command(3, 0); wait_idle();
    chk("R3 gap clk->iso", 32'(t_iso - t_clk), GAP);
    chk("R3 gap iso->rst", 32'(t_rst - t_iso), GAP);
    chk("R3 gap rst->pwr", 32'(t_pwr - t_rst), GAP);
    chk("R3 end after pwr", 32'(t_end > t_pwr), 1);
    rd(8'h04, d); chk("R3 status", d, 32'h2);
    chk("R3 clk", 32'(clk_en), 0);
    chk("R3 iso", 32'(iso_en), 32'hFFF);
    chk("R3 pwr", 32'(pwr_en), 32'(MASK));
  endtask

  task automatic t_polarity;
    command(5, 1); wait_idle();
    chk("R6 low-active on", 32'(pwr_en[5]), 0);
    chk("R6 clk on", 32'(clk_en[5]), 1);
    command(5, 0); wait_idle();
    chk("R6 low-active off", 32'(pwr_en[5]), 1);
  endtask

  task automatic t_timeout_up;
    logic [31:0] d;
    stuck_lo = 12'h080;
    command(7, 1); wait_idle();
    chk("R5 up timeout gap", 32'(t_end - t_pwr), POLL * TICK);
    rd(8'h04, d); chk("R5 up status", d, 32'h6);
    chk("R5 rst not released", 32'(rst_rel[7]), 0);
    chk("R5 iso kept", 32'(iso_en[7]), 1);
    chk("R5 clk kept", 32'(clk_en[7]), 0);
    stuck_lo = '0;
    command(7, 0); wait_idle();
    chk("R5 recover", 32'(pwr_en[7]), 0);
  endtask

  task automatic t_timeout_down;
    logic [31:0] d;
    command(3, 1); wait_idle();
    stuck_hi = 12'h008;
    command(3, 0); wait_idle();
    chk("R5 down timeout gap", 32'(t_end - t_pwr), POLL * TICK);
    rd(8'h04, d); chk("R5 down status", d, 32'h6);
    chk("R5 down clk", 32'(clk_en[3]), 0);
    stuck_hi = '0;
  endtask

  task automatic t_overrun;
    logic [31:0] d;
    command(0, 1);
    command(1, 1);
    wait_idle();
    rd(8'h04, d); chk("R8 overrun status", d, 32'hA);
    chk("R8 domain1 ignored", 32'(clk_en[1]), 0);
    chk("R8 domain1 pwr", 32'(rst_rel[1]), 0);
    chk("R8 domain0 done", 32'(clk_en[0]), 1);
  endtask

  task automatic t_invalid;
    logic [31:0] d;
    logic [ND-1:0] c0, i0, r0, q0;
    c0 = clk_en; i0 = iso_en; r0 = rst_rel; q0 = pwr_en;
    command(12, 1);
    #1 chk("R9 status", rdata, 32'hE);
    repeat (30) @(negedge clk);
    chk("R9 clk", 32'(clk_en), 32'(c0));
    chk("R9 iso", 32'(iso_en), 32'(i0));
    chk("R9 rst", 32'(rst_rel), 32'(r0));
    chk("R9 pwr", 32'(pwr_en), 32'(q0));
    rd(8'h04, d); chk("R9 not busy", 32'(d[0]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_up3();
    t_down3();
    t_polarity();
    t_timeout_up();
    t_timeout_down();
    t_overrun();
    t_invalid();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule